// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the programming registers for four DMA channels: a 16-bit base address and a 16-bit base count per channel, a live current address, and a transfer progress value. Software reaches them through a byte-wide register port. A single byte-pointer flip-flop is shared by all channels, so each 16-bit value is written or read as two consecutive byte accesses: low byte first, then high byte.

A width-shift parameter lets one design serve a byte-wide controller (shift 0) or a word-wide controller (shift 1). The shift moves the port address before decoding and scales the address and count values. Readback does not return the stored bytes. It returns live values: the current address moved by the progress, or the remaining count. The transfer engine, which lives outside this block, reports progress through a separate update port. Each channel's direction bit comes in as an input.

Top module: `dma_chan_regs`

## Requirements
- R1: The register index is bits [3:0] of `port_addr` shifted right by WSHIFT. Bits [2:1] select the channel. Bit 0 selects the register: 0 is the address register and 1 is the count register. An index with bit 3 set is not a channel register. An access to such an index changes no register, does not flip the byte pointer and leaves `rd_data` unchanged.
- R2: The byte pointer is 0 after reset. It flips on every channel-register access, read or write. When it is 0 the access uses the low byte (bits [7:0]); when it is 1 the access uses the high byte (bits [15:8]).
- R3: A low-byte write replaces bits [7:0] of the selected base register. The channel's current address and progress do not change.
- R4: A high-byte write replaces bits [15:8] of the selected base register. It then loads the current address with the new base address shifted left by WSHIFT and clears the progress to 0. If a progress update to the same channel arrives in the same cycle, the high-byte write wins.
- R5: The address register reads as current address plus progress when the channel's `dir_dec` bit is 0, and as current address minus progress when it is 1. The arithmetic is modulo 2^(16+WSHIFT).
- R6: The count register reads as the base count shifted left by WSHIFT, minus the progress, modulo 2^(16+WSHIFT).
- R7: The byte returned is bits [7:0] of the value from R5 or R6 shifted right by (WSHIFT + 8 × pointer). It appears on `rd_data` after the clock edge that takes the read. `rd_data` keeps its value in every other cycle.
- R8: When `prog_we` is high, `prog_val` is written into the progress of channel `prog_chan` at the clock edge.
- R9: Synchronous active-low reset clears all base registers, current addresses, progress values, the byte pointer and `rd_data` to 0.
- R10: When `wr_stb` and `rd_stb` are both high, only the write takes effect. The pointer flips once and `rd_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_addr | input | PORT_W | Register port address, before the width shift |
| wr_stb | input | 1 | Register write strobe |
| rd_stb | input | 1 | Register read strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered readback byte |
| dir_dec | input | 4 | Per-channel direction bit: 1 means the address decrements |
| prog_we | input | 1 | Progress update strobe |
| prog_chan | input | 2 | Channel that receives the progress update |
| prog_val | input | 16+WSHIFT | New progress value |

## Verification
The bench uses the word-wide setting, so every address, count and returned byte passes through the shift. It targets the following cases:

- **Pointer shared across channels.** Accesses alternate between channels. A design with a pointer per channel returns the wrong byte.
- **Non-channel indices.** Accesses to indices 8 to 15 are inserted. A design that flips the pointer on them, or writes a register, goes out of step on every later access.
- **Low versus high writes.** A design that reloads on the low byte, or fails to clear progress on the high byte, returns a moved address.
- **Same-cycle conflicts.** A progress update lands in the same cycle as a high-byte write. Both strobes are raised together. A design with the wrong priority shows a non-zero offset, or an `rd_data` that changed.
- **Wrap and direction.** Progress values that wrap, and the decrement direction, expose a design that adds when it should subtract or that truncates the value before the shift.

// File: rtl/dcr_pkg.sv
// Package: shared constants and types for the DMA channel register file.
// Assumes four channels and 16-bit base registers.
package dcr_pkg;
    localparam int BYTE_W = 8;
    localparam int BASE_W = 16;
    localparam int CHAN_N = 4;
    localparam int CHAN_W = $clog2(CHAN_N);

    typedef enum logic {
        SEL_ADDR  = 1'b0,
        SEL_COUNT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/dcr_byte_ptr.sv
// Module: byte-pointer flip-flop shared by every channel.
// It flips once per accepted channel-register access. The caller has
// already resolved read/write priority and removed non-channel indices.
module dcr_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    output logic ptr
);
    // Flip on each accepted access; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= 1'b0;
        else if (access) ptr <= ~ptr;
    end

    p_ptr_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> ptr != $past(ptr));
    p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> $stable(ptr));
endmodule

// File: rtl/dcr_channel.sv
// Module: register state for one channel.
// Holds the base address, base count, current address and progress.
// Assumes at most one of wr_lo_en and wr_hi_en is high in a cycle.
// A high-byte write overrides a progress update in the same cycle.
module dcr_channel
    import dcr_pkg::*;
#(
    parameter int WSHIFT = 0,
    localparam int VW = BASE_W + WSHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo_en,
    input  logic              wr_hi_en,
    input  reg_sel_e          sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              prog_we,
    input  logic [VW-1:0]     prog_val,
    output logic [BASE_W-1:0] base_addr,
    output logic [BASE_W-1:0] base_cnt,
    output logic [VW-1:0]     cur_addr,
    output logic [VW-1:0]     prog
);
    logic [BASE_W-1:0] base_addr_nx;
    logic [BASE_W-1:0] base_cnt_nx;

    // Merge the incoming byte into the selected base register.
    always_comb begin
        base_addr_nx = base_addr;
        base_cnt_nx  = base_cnt;
        if (wr_lo_en) begin
            if (sel == SEL_ADDR) base_addr_nx[7:0] = wdata;
            else                 base_cnt_nx[7:0]  = wdata;
        end else if (wr_hi_en) begin
            if (sel == SEL_ADDR) base_addr_nx[15:8] = wdata;
            else                 base_cnt_nx[15:8]  = wdata;
        end
    end

    // Store the base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
        end else begin
            base_addr <= base_addr_nx;
            base_cnt  <= base_cnt_nx;
        end
    end

    // Reload the current address on a high-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_addr <= '0;
        else if (wr_hi_en) cur_addr <= VW'(base_addr_nx) << WSHIFT;
    end

    // Progress: a high-byte write clears it, otherwise the update port loads it.
    always_ff @(posedge clk) begin
        if (!rst_n) prog <= '0;
        else if (wr_hi_en) prog <= '0;
        else if (prog_we) prog <= prog_val;
    end

    p_lo_keeps_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_en && !prog_we) |=> ($stable(cur_addr) && $stable(prog)));
    p_hi_clears_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_en |=> prog == '0);
    p_prog_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && !wr_hi_en) |=> prog == $past(prog_val));
endmodule

// File: rtl/dcr_readback.sv
// Module: computes the live readback byte for one channel.
// Purely combinational. The caller selects the channel.
module dcr_readback
    import dcr_pkg::*;
#(
    parameter int WSHIFT = 0,
    localparam int VW = BASE_W + WSHIFT
) (
    input  reg_sel_e          sel,
    input  logic              dir_dec,
    input  logic              ptr,
    input  logic [BASE_W-1:0] base_cnt,
    input  logic [VW-1:0]     cur_addr,
    input  logic [VW-1:0]     prog,
    output logic [BYTE_W-1:0] byte_out
);
    logic [VW-1:0] live_val;
    logic [VW-1:0] scaled;

    // Compute the live address or the remaining count.
    always_comb begin
        if (sel == SEL_COUNT)
            live_val = (VW'(base_cnt) << WSHIFT) - prog;
        else if (dir_dec)
            live_val = cur_addr - prog;
        else
            live_val = cur_addr + prog;
    end

    // Undo the width shift, then pick the byte the pointer selects.
    always_comb begin
        scaled   = live_val >> WSHIFT;
        byte_out = ptr ? scaled[15:8] : scaled[7:0];
    end
endmodule

// File: rtl/dma_chan_regs.sv
// Module: top of the DMA channel address/count register file.
// Decodes the port index, gives writes priority over reads, drives the
// shared byte pointer, and registers the readback byte.
// Assumes PORT_W >= 4 + WSHIFT.
module dma_chan_regs
    import dcr_pkg::*;
#(
    parameter int WSHIFT = 0,
    parameter int PORT_W = 5,
    localparam int VW = BASE_W + WSHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [CHAN_N-1:0] dir_dec,
    input  logic              prog_we,
    input  logic [CHAN_W-1:0] prog_chan,
    input  logic [VW-1:0]     prog_val
);
    logic [PORT_W-1:0] shifted;
    logic [3:0]        idx;
    logic [CHAN_W-1:0] ch;
    reg_sel_e          sel;
    logic              is_chan, acc_wr, acc_rd, ptr;
    logic [BYTE_W-1:0] rb_byte;

    logic [BASE_W-1:0] base_addr [CHAN_N];
    logic [BASE_W-1:0] base_cnt  [CHAN_N];
    logic [VW-1:0]     cur_addr  [CHAN_N];
    logic [VW-1:0]     prog      [CHAN_N];

    // Decode the index and resolve the access; a write beats a read.
    always_comb begin
        shifted = port_addr >> WSHIFT;
        idx     = shifted[3:0];
        ch      = idx[CHAN_W:1];
        sel     = reg_sel_e'(idx[0]);
        is_chan = !idx[3];
        acc_wr  = wr_stb && is_chan;
        acc_rd  = rd_stb && !wr_stb && is_chan;
    end

    dcr_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (acc_wr || acc_rd),
        .ptr    (ptr)
    );

    for (genvar i = 0; i < CHAN_N; i++) begin : g_chan
        dcr_channel #(.WSHIFT(WSHIFT)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo_en  (acc_wr && !ptr && (ch == CHAN_W'(i))),
            .wr_hi_en  (acc_wr &&  ptr && (ch == CHAN_W'(i))),
            .sel       (sel),
            .wdata     (wr_data),
            .prog_we   (prog_we && (prog_chan == CHAN_W'(i))),
            .prog_val  (prog_val),
            .base_addr (base_addr[i]),
            .base_cnt  (base_cnt[i]),
            .cur_addr  (cur_addr[i]),
            .prog      (prog[i])
        );
    end

    dcr_readback #(.WSHIFT(WSHIFT)) u_rb (
        .sel      (sel),
        .dir_dec  (dir_dec[ch]),
        .ptr      (ptr),
        .base_cnt (base_cnt[ch]),
        .cur_addr (cur_addr[ch]),
        .prog     (prog[ch]),
        .byte_out (rb_byte)
    );

    // Capture the readback byte when a read is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (acc_rd) rd_data <= rb_byte;
    end

    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> $stable(rd_data));
    p_both_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rd_stb) |=> $stable(rd_data));
    p_nonchan_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idx[3] && (wr_stb || rd_stb)) |=> $stable(rd_data));
endmodule

// File: tb/dma_chan_regs_bench.sv
// Bench: directed corner cases followed by seeded random accesses.
// Every result is compared against a model built from the requirements.
module dma_chan_regs_bench;
    localparam int WS = 1;
    localparam int PW = 5;
    localparam int VW = 16 + WS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] port_addr = '0;
    logic          wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic [3:0]    dir_dec = '0;
    logic          prog_we = 1'b0;
    logic [1:0]    prog_chan = '0;
    logic [VW-1:0] prog_val = '0;

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    // Model state.
    logic [15:0]   m_ba [4];
    logic [15:0]   m_bc [4];
    logic [VW-1:0] m_cur [4];
    logic [VW-1:0] m_prog [4];
    bit            m_ptr;
    logic [7:0]    m_rd;

    always #2 clk = ~clk;

    dma_chan_regs #(.WSHIFT(WS), .PORT_W(PW)) u_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data),
        .dir_dec(dir_dec), .prog_we(prog_we), .prog_chan(prog_chan),
        .prog_val(prog_val)
    );

    // Expected byte for a channel register, from R5, R6 and R7.
    function automatic logic [7:0] exp_byte(int c, bit reg_cnt);
        logic [VW-1:0] v;
        if (reg_cnt)          v = (VW'(m_bc[c]) << WS) - m_prog[c];
        else if (dir_dec[c])  v = m_cur[c] - m_prog[c];
        else                  v = m_cur[c] + m_prog[c];
        v = v >> (WS + 8 * int'(m_ptr));
        return v[7:0];
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus. The model updates at the edge, then rd_data is checked.
    task automatic step(bit wr, bit rd, logic [3:0] idx, logic [7:0] d,
                        bit pwe, int pch, logic [VW-1:0] pv, string tag);
        bit valid;
        int c;
        @(negedge clk);
        port_addr = PW'(idx) << WS;
        wr_stb = wr; rd_stb = rd; wr_data = d;
        prog_we = pwe; prog_chan = 2'(pch); prog_val = pv;
        valid = !idx[3] && (wr || rd);
        c = int'(idx[2:1]);
        if (valid && rd && !wr) m_rd = exp_byte(c, idx[0]);
        if (pwe) m_prog[pch] = pv;
        if (valid && wr) begin
            if (!m_ptr) begin
                if (idx[0]) m_bc[c][7:0] = d; else m_ba[c][7:0] = d;
            end else begin
                if (idx[0]) m_bc[c][15:8] = d; else m_ba[c][15:8] = d;
                m_cur[c]  = VW'(m_ba[c]) << WS;
                m_prog[c] = '0;
            end
        end
        if (valid) m_ptr = !m_ptr;
        @(posedge clk);
        #1;
        wr_stb = 1'b0; rd_stb = 1'b0; prog_we = 1'b0;
        check(tag, rd_data, m_rd);
    endtask

    task automatic rd(logic [3:0] idx, string tag);
        step(1'b0, 1'b1, idx, 8'h00, 1'b0, 0, '0, tag);
    endtask

    task automatic wr(logic [3:0] idx, logic [7:0] d, string tag);
        step(1'b1, 1'b0, idx, d, 1'b0, 0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: rd_data=%h expected=%h", rd_data, m_rd);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = '0; m_bc[i] = '0; m_cur[i] = '0; m_prog[i] = '0;
        end
        m_ptr = 1'b0; m_rd = '0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R9 reset rd_data", rd_data, 8'h00);
        rd(4'd2, "R9 address after reset low");
        rd(4'd3, "R9 count after reset high");

        // R4: program channel 1 address 0x1234 and count 0x0010, then read back.
        wr(4'd2, 8'h34, "R3 low write addr");
        wr(4'd2, 8'h12, "R4 high write addr");
        rd(4'd2, "R4 reload low");
        rd(4'd2, "R4 reload high");
        wr(4'd3, 8'h10, "R3 low write count");
        wr(4'd3, 8'h00, "R4 high write count");
        rd(4'd3, "R6 count low");
        rd(4'd3, "R6 count high");

        // R8 and R5: progress moves the address in either direction.
        step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1, 17'd6, "R8 progress load");
        rd(4'd2, "R5 incr low");
        rd(4'd2, "R5 incr high");
        dir_dec[1] = 1'b1;
        rd(4'd2, "R5 decr low");
        rd(4'd2, "R5 decr high");
        rd(4'd3, "R6 count after progress");
        rd(4'd3, "R6 count after progress high");

        // R3: a low write leaves the live address as it was.
        wr(4'd2, 8'hAA, "R3 low write no reload");
        rd(4'd2, "R3 live addr unchanged high");
        rd(4'd2, "R3 live addr unchanged low");

        // R1: non-channel indices change nothing.
        wr(4'd9, 8'h55, "R1 index 9 write ignored");
        rd(4'd15, "R1 index 15 read ignored");
        rd(4'd2, "R1 pointer unmoved");

        // R2: the pointer is shared across channels.
        wr(4'd4, 8'h77, "R2 ch2 low");
        rd(4'd2, "R2 ch1 read uses high byte");

        // R10: both strobes, write wins.
        step(1'b1, 1'b1, 4'd6, 8'h3C, 1'b0, 0, '0, "R10 both strobes");
        rd(4'd6, "R10 write took effect");

        // R4: high write overrides a same-cycle progress update.
        wr(4'd0, 8'h01, "R4 ch0 low");
        step(1'b1, 1'b0, 4'd0, 8'h80, 1'b1, 0, 17'h1FFFF, "R4 hi beats progress");
        rd(4'd0, "R4 progress cleared low");
        rd(4'd0, "R4 progress cleared high");

        // R5/R6: wrapping progress.
        step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 0, 17'h1FFFE, "R8 wrap load");
        rd(4'd1, "R6 count wrap low");
        rd(4'd0, "R5 addr wrap high");

        // Random phase.
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] ix;
            bit w, r, pwe;
            string tg;
            ix  = (($urandom % 8) == 0) ? 4'(8 + $urandom % 8) : 4'($urandom % 8);
            w   = ($urandom % 3) == 0;
            r   = !w || (($urandom % 10) == 0);
            pwe = ($urandom % 4) == 0;
            if (($urandom % 50) == 0) dir_dec = 4'($urandom);
            if (ix[3])     tg = "R1 random";
            else if (w)    tg = "R7 random write";
            else if (ix[0]) tg = "R6 random";
            else           tg = "R5 random";
            step(w, r, ix, 8'($urandom), pwe, int'($urandom % 4),
                 VW'($urandom), tg);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule